// File: doc/BRIEF.md
# Display Bridge Configuration Register Target on I2C

This block is a two-wire serial bus target that gives a host access to a bank of 256 sixteen-bit configuration registers for a display-output bridge. Each register is selected by an 8-bit index. Register data travels low byte first. The block watches the clock and data lines through synchronisers. It detects START and STOP conditions, shifts bytes in on rising clock edges, and drives the data line low (open drain) only while the clock is low.

Two transaction shapes are decoded. A write carries the target address with the direction bit clear, then the index, the low data byte and the high data byte. A read carries the target address with the direction bit set. The host then still drives the index byte, with no repeated START in between. After that the target returns the low byte and then the high byte. A few registers have real effects. The identity register echoes the bus address. The control register drives the output enables and carries an interlock between the LCD and the repeater bypass. The format register selects the panel pixel layout and the LVDS/CMOS choice. The status register reports a synchronised panel-power input. A small window of general storage registers completes the bank, and every other index reads as zero.

Top module: `dvo_cfg_i2c_tgt`

## Requirements
- R1: A write (START, address byte with bit 0 = 0, index, low byte, high byte, STOP) updates the selected register, and the target ACKs all four bytes. A STOP that arrives before the high byte leaves the register unchanged.
- R2: A read (START, address byte with bit 0 = 1, index byte driven by the host, then two bytes driven by the target) returns bits [7:0] and then bits [15:8] of the indexed register, each sent MSB first. The target ACKs the address and the index, and changes the data line only while the synchronised clock is low.
- R3: Index 0x00 reads as the 7-bit bus address in bits [6:0], with all other bits zero. Writes to index 0x00 have no effect.
- R4: At index 0x30, bit 15 equals the panel_on_i input after two-flop synchronisation, and all other bits read zero. Writes to index 0x30 have no effect.
- R5: At index 0x01, bit 0 drives dvo_clk_en, bit 1 drives bypass_en, bit 2 drives lcd_en, bit 3 drives fitter_en and bit 4 drives dither_en. Bits [15:5] read zero, and these outputs change only as a result of a register write.
- R6: A write to index 0x01 that has both bit 1 and bit 2 set stores bit 2 as 0 and keeps the other bits as written. lcd_en and bypass_en are never both 1.
- R7: At index 0x10, bits [3:2] drive out_format (0 = single 18-bit, 1 = single 24-bit, 2 = dual 18-bit, 3 = dual 24-bit) and bit 4 drives lvds_sel (1 = LVDS, 0 = CMOS). All other bits read zero.
- R8: The indices 0x20 to 0x27 hold full 16-bit read/write values. Every index not named in R3 to R8 reads zero and ignores writes.
- R9: An address byte whose upper seven bits differ from the bus address is not ACKed. The target does not drive the data line for the rest of that transaction, and no register changes.
- R10: After the host NACKs a byte the target has sent, the target releases the data line for the rest of the transaction. A STOP releases the data line and returns the target to idle from any state.
- R11: After reset the data line is released, all control outputs are 0, and every writable register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| panel_on_i | input | 1 | Panel not yet safely powered off (asynchronous) |
| dvo_clk_en | output | 1 | Video input clock enable (index 0x01 bit 0) |
| bypass_en | output | 1 | Repeater bypass enable (index 0x01 bit 1) |
| lcd_en | output | 1 | LCD enable (index 0x01 bit 2) |
| fitter_en | output | 1 | Panel fitter enable (index 0x01 bit 3) |
| dither_en | output | 1 | Dithering enable (index 0x01 bit 4) |
| out_format | output | 2 | Panel pixel layout (index 0x10 bits [3:2]) |
| lvds_sel | output | 1 | LVDS rather than CMOS output (index 0x10 bit 4) |

## Verification
The bench sweeps every index with a read. This finds a decoder that aliases the storage window onto neighbouring indices, and a design that lets fixed or unimplemented registers keep written data instead of reading the required constant or zero. It writes both interlocked control bits together. A design without the interlock would show lcd_en and bypass_en high at once, and one that rejected the whole write would lose the other enables. It NACKs the low byte of a read and then keeps clocking. A target that fails to release would pull the line low and corrupt the bits that follow. It also sends a foreign address, and it ends a write early with STOP. A careless design would ACK the foreign address or commit a half-received write.

// File: rtl/dvo_cfg_pkg.sv
package dvo_cfg_pkg;

   localparam logic [7:0] IDX_IDENT = 8'h00;
   localparam logic [7:0] IDX_CTRL  = 8'h01;
   localparam logic [7:0] IDX_FMT   = 8'h10;
   localparam logic [7:0] IDX_PSTAT = 8'h30;

   typedef enum logic [1:0] {
      LK_IDLE,
      LK_RX,
      LK_TX,
      LK_SKIP
   } link_st_e;

   typedef struct packed {
      logic dither;
      logic fitter;
      logic lcd;
      logic bypass;
      logic clk_en;
   } ctrl_t;

   typedef struct packed {
      logic       lvds;
      logic [1:0] layout;
   } fmt_t;

   function automatic bit idx_in_window(logic [7:0] idx, logic [7:0] base, int count);
      return (int'(idx) >= int'(base)) && (int'(idx) < int'(base) + count);
   endfunction

endpackage

// File: rtl/dvo_cfg_sync.sv
module dvo_cfg_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dvo_cfg_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dvo_cfg_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dvo_cfg_link.sv
module dvo_cfg_link
   import dvo_cfg_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR = 7'h44
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_s,
   input  logic        sda_s,
   output logic        sda_oe,
   output logic        stop_det,
   output logic        wr_en,
   output logic [7:0]  wr_idx,
   output logic [15:0] wr_data,
   output logic [7:0]  rd_idx,
   input  logic [15:0] rd_data
);

   localparam int         BITS     = 8;
   localparam logic [3:0] LAST_BIT = 4'(BITS);
   localparam logic [3:0] ACK_BIT  = 4'(BITS + 1);

   link_st_e    state;
   logic        scl_d, sda_d;
   logic        scl_rise, scl_fall, start_det;
   logic [3:0]  bitcnt;
   logic [1:0]  pos;
   logic        rw;
   logic [7:0]  shreg;
   logic [7:0]  idx_q;
   logic [7:0]  lo_q;
   logic [15:0] txq;
   logic [7:0]  txsh;
   logic        m_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
   assign rd_idx    = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= LK_IDLE;
         sda_oe  <= 1'b0;
         bitcnt  <= '0;
         pos     <= '0;
         rw      <= 1'b0;
         shreg   <= '0;
         idx_q   <= '0;
         lo_q    <= '0;
         txq     <= '0;
         txsh    <= '0;
         m_ack   <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            state  <= LK_IDLE;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            state  <= LK_RX;
            sda_oe <= 1'b0;
            bitcnt <= '0;
            pos    <= '0;
         end else begin
            unique case (state)
               LK_RX: begin
                  if (scl_rise) begin
                     if (bitcnt < LAST_BIT) shreg <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt == LAST_BIT) begin
                        unique case (pos)
                           2'd0: begin
                              if (shreg[7:1] == TGT_ADDR) begin
                                 sda_oe <= 1'b1;
                                 rw     <= shreg[0];
                              end else begin
                                 state <= LK_SKIP;
                              end
                           end
                           2'd1: begin
                              sda_oe <= 1'b1;
                              idx_q  <= shreg;
                              txq    <= rd_data;
                           end
                           2'd2: begin
                              sda_oe <= 1'b1;
                              lo_q   <= shreg;
                           end
                           default: begin
                              sda_oe  <= 1'b1;
                              wr_en   <= 1'b1;
                              wr_idx  <= idx_q;
                              wr_data <= {shreg, lo_q};
                           end
                        endcase
                     end else if (bitcnt == ACK_BIT) begin
                        bitcnt <= '0;
                        pos    <= pos + 2'd1;
                        if (pos == 2'd3) begin
                           state  <= LK_SKIP;
                           sda_oe <= 1'b0;
                        end else if (pos == 2'd1 && rw) begin
                           state  <= LK_TX;
                           txsh   <= txq[7:0];
                           sda_oe <= ~txq[7];
                        end else begin
                           sda_oe <= 1'b0;
                        end
                     end
                  end
               end
               LK_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 4'd1;
                     if (bitcnt == LAST_BIT) m_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (bitcnt != '0 && bitcnt < LAST_BIT) begin
                        txsh   <= {txsh[6:0], 1'b0};
                        sda_oe <= ~txsh[6];
                     end else if (bitcnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                     end else if (bitcnt == ACK_BIT) begin
                        bitcnt <= '0;
                        if (m_ack && pos == 2'd2) begin
                           pos    <= 2'd3;
                           txsh   <= txq[15:8];
                           sda_oe <= ~txq[15];
                        end else begin
                           state  <= LK_SKIP;
                           sda_oe <= 1'b0;
                        end
                     end
                  end
               end
               LK_SKIP: sda_oe <= 1'b0;
               default: sda_oe <= 1'b0;
            endcase
         end
      end
   end

endmodule

// File: rtl/dvo_cfg_bank.sv
module dvo_cfg_bank
   import dvo_cfg_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR = 7'h44,
   parameter logic [7:0] SCR_BASE = 8'h20,
   parameter int         SCR_CNT  = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  wr_idx,
   input  logic [15:0] wr_data,
   input  logic [7:0]  rd_idx,
   output logic [15:0] rd_data,
   input  logic        panel_s,
   output ctrl_t       ctrl_o,
   output fmt_t        fmt_o
);

   localparam int         SCR_AW  = (SCR_CNT > 1) ? $clog2(SCR_CNT) : 1;
   localparam logic [7-SCR_AW:0] SCR_TAG = SCR_BASE[7:SCR_AW];

   if (SCR_CNT > 0 && (SCR_CNT < 2 || (SCR_CNT & (SCR_CNT - 1)) != 0)) begin : g_bad_cnt
      $error("dvo_cfg_bank: SCR_CNT must be 0 or a power of two of at least 2");
   end
   if (SCR_CNT > 0 && SCR_BASE[SCR_AW-1:0] != '0) begin : g_bad_align
      $error("dvo_cfg_bank: SCR_BASE must be aligned to SCR_CNT");
   end
   if (int'(SCR_BASE) + SCR_CNT > 256) begin : g_bad_range
      $error("dvo_cfg_bank: storage window runs past index 255");
   end
   if (idx_in_window(IDX_IDENT, SCR_BASE, SCR_CNT) || idx_in_window(IDX_CTRL, SCR_BASE, SCR_CNT) ||
       idx_in_window(IDX_FMT, SCR_BASE, SCR_CNT)   || idx_in_window(IDX_PSTAT, SCR_BASE, SCR_CNT))
   begin : g_bad_overlap
      $error("dvo_cfg_bank: storage window overlaps a fixed register");
   end

   ctrl_t       ctrl_q, ctrl_nxt;
   fmt_t        fmt_q;
   logic        scr_hit;
   logic [15:0] scr_rd;

   // interlock: LCD may not be enabled together with the bypass path
   always_comb begin
      ctrl_nxt = ctrl_t'(wr_data[4:0]);
      if (ctrl_nxt.lcd && ctrl_nxt.bypass) ctrl_nxt.lcd = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         fmt_q  <= '0;
      end else if (wr_en) begin
         if (wr_idx == IDX_CTRL) ctrl_q <= ctrl_nxt;
         if (wr_idx == IDX_FMT)  fmt_q  <= fmt_t'(wr_data[4:2]);
      end
   end

   if (SCR_CNT > 0) begin : g_scratch
      logic [15:0] scr [2**SCR_AW];
      logic        wr_hit;

      assign wr_hit  = (wr_idx[7:SCR_AW] == SCR_TAG);
      assign scr_hit = (rd_idx[7:SCR_AW] == SCR_TAG);
      assign scr_rd  = scr[rd_idx[SCR_AW-1:0]];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < 2**SCR_AW; k++) scr[k] <= '0;
         end else if (wr_en && wr_hit) begin
            scr[wr_idx[SCR_AW-1:0]] <= wr_data;
         end
      end
   end else begin : g_no_scratch
      assign scr_hit = 1'b0;
      assign scr_rd  = '0;
   end

   always_comb begin
      rd_data = '0;
      if (scr_hit) rd_data = scr_rd;
      case (rd_idx)
         IDX_IDENT: rd_data = {9'b0, TGT_ADDR};
         IDX_CTRL:  rd_data = {11'b0, ctrl_q};
         IDX_FMT:   rd_data = {11'b0, fmt_q, 2'b00};
         IDX_PSTAT: rd_data = {panel_s, 15'b0};
         default:   ;
      endcase
   end

   assign ctrl_o = ctrl_q;
   assign fmt_o  = fmt_q;

endmodule

// File: rtl/dvo_cfg_i2c_tgt.sv
module dvo_cfg_i2c_tgt
   import dvo_cfg_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR    = 7'h44,
   parameter logic [7:0] SCR_BASE    = 8'h20,
   parameter int         SCR_CNT     = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic       panel_on_i,
   output logic       dvo_clk_en,
   output logic       bypass_en,
   output logic       lcd_en,
   output logic       fitter_en,
   output logic       dither_en,
   output logic [1:0] out_format,
   output logic       lvds_sel
);

   logic        scl_s, sda_s, panel_s;
   logic        stop_det;
   logic        wr_en;
   logic [7:0]  wr_idx, rd_idx;
   logic [15:0] wr_data, rd_data;
   ctrl_t       ctrl;
   fmt_t        fmt;

   dvo_cfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     ({scl_s, sda_s})
   );

   dvo_cfg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_panel_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (panel_on_i),
      .q     (panel_s)
   );

   dvo_cfg_link #(.TGT_ADDR(TGT_ADDR)) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .sda_oe   (sda_oe),
      .stop_det (stop_det),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data)
   );

   dvo_cfg_bank #(.TGT_ADDR(TGT_ADDR), .SCR_BASE(SCR_BASE), .SCR_CNT(SCR_CNT)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .panel_s (panel_s),
      .ctrl_o  (ctrl),
      .fmt_o   (fmt)
   );

   assign dvo_clk_en = ctrl.clk_en;
   assign bypass_en  = ctrl.bypass;
   assign lcd_en     = ctrl.lcd;
   assign fitter_en  = ctrl.fitter;
   assign dither_en  = ctrl.dither;
   assign out_format = fmt.layout;
   assign lvds_sel   = fmt.lvds;

endmodule

// File: rtl/dvo_cfg_i2c_tgt_chk.sv
module dvo_cfg_i2c_tgt_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_q,
   input logic       sda_oe,
   input logic       stop_det,
   input logic       wr_en,
   input logic       dvo_clk_en,
   input logic       bypass_en,
   input logic       lcd_en,
   input logic       fitter_en,
   input logic       dither_en,
   input logic [1:0] out_format,
   input logic       lvds_sel
);

   assert_lcd_bypass_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(lcd_en && bypass_en));

   assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_q);

   assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({dvo_clk_en, bypass_en, lcd_en, fitter_en, dither_en, out_format, lvds_sel}));

endmodule

bind dvo_cfg_i2c_tgt dvo_cfg_i2c_tgt_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_q      (scl_s),
   .sda_oe     (sda_oe),
   .stop_det   (stop_det),
   .wr_en      (wr_en),
   .dvo_clk_en (dvo_clk_en),
   .bypass_en  (bypass_en),
   .lcd_en     (lcd_en),
   .fitter_en  (fitter_en),
   .dither_en  (dither_en),
   .out_format (out_format),
   .lvds_sel   (lvds_sel)
);

// File: tb/dvo_cfg_i2c_tgt_test.sv
module dvo_cfg_i2c_tgt_test;

   localparam logic [6:0] ADDR = 7'h44;
   localparam int         Q    = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       md = 1'b0;
   logic       panel = 1'b0;
   logic       sda_line;
   logic       sda_oe;
   logic       dvo_clk_en, bypass_en, lcd_en, fitter_en, dither_en, lvds_sel;
   logic [1:0] out_format;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   bit  mon_en = 1'b0;
   bit  saw_drive = 1'b0;
   logic [15:0] shadow [256];

   assign sda_line = ~(md | sda_oe);

   always #10 clk = ~clk;

   dvo_cfg_i2c_tgt uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_line),
      .sda_oe     (sda_oe),
      .panel_on_i (panel),
      .dvo_clk_en (dvo_clk_en),
      .bypass_en  (bypass_en),
      .lcd_en     (lcd_en),
      .fitter_en  (fitter_en),
      .dither_en  (dither_en),
      .out_format (out_format),
      .lvds_sel   (lvds_sel)
   );

   always @(negedge clk) if (mon_en && sda_oe) saw_drive = 1'b1;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bit_out(input logic b);
      md = ~b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
   endtask

   task automatic bit_in(output logic b);
      md = 1'b0; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0; tick(Q);
   endtask

   task automatic bus_start();
      md = 1'b1; tick(Q); scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      md = 1'b1; tick(Q); scl = 1'b1; tick(Q); md = 1'b0; tick(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      bit_in(b);
      ack = ~b;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         d[i] = b;
      end
      bit_out(~give_ack);
   endtask

   task automatic reg_write(input logic [7:0] idx, input logic [15:0] v, output logic [3:0] acks);
      bus_start();
      send_byte({ADDR, 1'b0}, acks[0]);
      send_byte(idx, acks[1]);
      send_byte(v[7:0], acks[2]);
      send_byte(v[15:8], acks[3]);
      bus_stop();
      shadow[idx] = v;
   endtask

   task automatic reg_read(input logic [7:0] idx, output logic [15:0] v, output logic [1:0] acks);
      logic [7:0] lo, hi;
      bus_start();
      send_byte({ADDR, 1'b1}, acks[0]);
      send_byte(idx, acks[1]);
      recv_byte(1'b1, lo);
      recv_byte(1'b0, hi);
      bus_stop();
      v = {hi, lo};
   endtask

   function automatic logic [15:0] exp_val(input int idx);
      logic [15:0] v;
      v = shadow[idx];
      if (idx == 8'h00) return {9'b0, ADDR};
      if (idx == 8'h01) begin
         v = v & 16'h001F;
         if (v[1] && v[2]) v[2] = 1'b0;
         return v;
      end
      if (idx == 8'h10) return v & 16'h001C;
      if (idx == 8'h30) return {panel, 15'b0};
      if (idx >= 8'h20 && idx <= 8'h27) return v;
      return 16'h0000;
   endfunction

   function automatic string tag_of(input int idx);
      if (idx == 8'h00) return "R3";
      if (idx == 8'h01) return "R5";
      if (idx == 8'h10) return "R7";
      if (idx == 8'h30) return "R4";
      return "R8";
   endfunction

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [3:0]  wa;
      logic [1:0]  ra;
      logic [15:0] rv;
      logic [7:0]  bb;
      logic        a;

      for (int i = 0; i < 256; i++) shadow[i] = 16'h0000;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R11: reset state
      chk("R11 sda released", {31'b0, sda_oe}, 32'd0);
      chk("R11 outputs", {24'b0, dvo_clk_en, bypass_en, lcd_en, fitter_en, dither_en, out_format, lvds_sel}, 32'd0);
      reg_read(8'h20, rv, ra);
      chk("R11 storage after reset", {16'b0, rv}, 32'd0);
      chk("R2 read acks", {30'b0, ra}, 32'd3);

      // R1: write acks and readback
      reg_write(8'h21, 16'h1234, wa);
      chk("R1 write acks", {28'b0, wa}, 32'hF);
      reg_read(8'h21, rv, ra);
      chk("R1 readback", {16'b0, rv}, 32'h1234);

      // R10 / R1: STOP before high byte commits nothing
      bus_start();
      send_byte({ADDR, 1'b0}, a);
      send_byte(8'h21, a);
      send_byte(8'hAA, a);
      bus_stop();
      chk("R10 sda released after stop", {31'b0, sda_oe}, 32'd0);
      reg_read(8'h21, rv, ra);
      chk("R1 partial write ignored", {16'b0, rv}, 32'h1234);

      // R9: foreign address
      reg_write(8'h22, 16'hBEEF, wa);
      saw_drive = 1'b0;
      mon_en = 1'b1;
      bus_start();
      send_byte({ADDR ^ 7'h01, 1'b0}, a);
      chk("R9 foreign address nack", {31'b0, a}, 32'd0);
      send_byte(8'h22, a);
      send_byte(8'h11, a);
      send_byte(8'h22, a);
      bus_stop();
      mon_en = 1'b0;
      chk("R9 no drive", {31'b0, saw_drive}, 32'd0);
      reg_read(8'h22, rv, ra);
      chk("R9 register unchanged", {16'b0, rv}, 32'hBEEF);

      // R10: host NACKs the low byte, target must stay off the line
      saw_drive = 1'b0;
      bus_start();
      send_byte({ADDR, 1'b1}, a);
      send_byte(8'h22, a);
      recv_byte(1'b0, bb);
      chk("R2 low byte first", {24'b0, bb}, 32'hEF);
      mon_en = 1'b1;
      recv_byte(1'b0, bb);
      mon_en = 1'b0;
      chk("R10 line released after nack", {24'b0, bb}, 32'hFF);
      chk("R10 no drive after nack", {31'b0, saw_drive}, 32'd0);
      bus_stop();

      // R6 / R5: interlock and control outputs
      reg_write(8'h01, 16'h0006, wa);
      reg_read(8'h01, rv, ra);
      chk("R6 lcd masked when bypass set", {16'b0, rv}, 32'h0002);
      chk("R6 outputs", {30'b0, lcd_en, bypass_en}, 32'h1);
      reg_write(8'h01, 16'hFFE4, wa);
      reg_read(8'h01, rv, ra);
      chk("R5 upper bits zero", {16'b0, rv}, 32'h0004);
      chk("R5 lcd output", {31'b0, lcd_en}, 32'd1);
      reg_write(8'h01, 16'h001F, wa);
      reg_read(8'h01, rv, ra);
      chk("R6 all enables", {16'b0, rv}, 32'h001B);
      chk("R5 output map", {27'b0, dither_en, fitter_en, lcd_en, bypass_en, dvo_clk_en}, 32'h1B);
      reg_write(8'h01, 16'h0011, wa);
      chk("R5 output map 2", {27'b0, dither_en, fitter_en, lcd_en, bypass_en, dvo_clk_en}, 32'h11);

      // R7: all format codes
      for (int m = 0; m < 4; m++) begin
         for (int l = 0; l < 2; l++) begin
            reg_write(8'h10, 16'hFFE3 | 16'(l << 4) | 16'(m << 2), wa);
            chk("R7 out_format", {30'b0, out_format}, 32'(m));
            chk("R7 lvds_sel", {31'b0, lvds_sel}, 32'(l));
            reg_read(8'h10, rv, ra);
            chk("R7 readback", {16'b0, rv}, 32'(l << 4) | 32'(m << 2));
         end
      end

      // R4: panel status
      panel = 1'b1;
      tick(8);
      reg_read(8'h30, rv, ra);
      chk("R4 panel on", {16'b0, rv}, 32'h8000);
      reg_write(8'h30, 16'h7FFF, wa);
      reg_read(8'h30, rv, ra);
      chk("R4 write ignored", {16'b0, rv}, 32'h8000);
      panel = 1'b0;
      tick(8);
      reg_read(8'h30, rv, ra);
      chk("R4 panel off", {16'b0, rv}, 32'h0000);

      // R3 / R8: write sweep then full read sweep
      for (int i = 0; i < 256; i++) begin
         if (i < 8'h40 || (i % 32) == 0)
            reg_write(8'(i), {~8'(i), 8'(i) ^ 8'h5A}, wa);
      end
      for (int i = 0; i < 256; i++) begin
         reg_read(8'(i), rv, ra);
         chk(tag_of(i), {16'b0, rv}, {16'b0, exp_val(i)});
      end
      chk("R5 outputs after sweep", {27'b0, dither_en, fitter_en, lcd_en, bypass_en, dvo_clk_en}, 32'h1B);
      chk("R7 outputs after sweep", {29'b0, lvds_sel, out_format}, 32'h2);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule